// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Channel

This block is one channel of a peripheral DMA engine. It copies a run of data items between memory and a device register. Software sets it up through a small word-addressed register window. A global word carries a master enable. Four channel words hold the channel control, the width and addressing options, the source address and the destination address. Once software sets the channel enable, the channel moves one item per beat. Each beat reads the source and then writes the same data to the destination, over a simple request/acknowledge memory port.

Transfer length is given as a burst type and a burst count. When the last beat ends, or when a bus error ends the transfer early, the channel drops its own enable and records a status code. It raises its interrupt if the matching interrupt enable is set. Software can pause the channel at a beat boundary and later resume it. Software can also abandon the transfer outright. While the channel runs, the two address registers read back the live addresses, so software can see how far the transfer has got.

Top module: `dmac_channel`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_req` is low.
- R2: The global word is at offset 0x00, with its master enable at bit 31. The channel block starts at 0x10*(CH_IDX+1) and holds control A at +0x0, control B at +0x4, source address at +0x8 and destination address at +0xC. Control A fields: enable bit 31, pause bit 30, request select 28:24, burst type 23:20, burst count 15:0. Control B fields: width 27:26, fixed source 25, fixed destination 24, error interrupt enable 20, completion interrupt enable 19, status 18:16. Written fields read back unchanged.
- R3: Burst type 0xF gives 16 beats per burst, 0xD gives 8, 0xB gives 4, and any other code gives 1. A burst count of N moves exactly (N+1) bursts, with no extra beat.
- R4: Width code 0 moves 1 byte per beat, code 1 moves 2 bytes, and code 2 or 3 moves 4 bytes. `mem_size` carries 0, 1 or 2 for these widths. A non-fixed address advances by that byte count after each beat.
- R5: Control B bit 25 holds the source address constant. Bit 24 holds the destination address constant.
- R6: After the last beat, the channel clears its enable and sets status to 1. `irq` is high exactly when the completion interrupt enable (bit 19) is set.
- R7: An error response on either access ends the transfer. The channel clears its enable and sets status to 2, and `irq` is high when bit 20 is set. The addresses stop at the failed beat.
- R8: A control B write whose status field is zero clears the status and drops `irq`. A write with a nonzero status field leaves the status unchanged.
- R9: While the master enable is clear, no beat starts. Setting it lets the pending transfer run to completion.
- R10: While pause is set, no new beat starts and progress is kept. Clearing pause resumes the transfer, and every remaining item arrives intact.
- R11: Clearing the channel enable drops `mem_req` right after the write's clock edge. No further access follows, and the status is not touched.
- R12: The address registers read back the live addresses during a transfer. Writes to them are ignored while the channel is active.
- R13: Each beat reads the source first and then writes exactly the data it read to the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | ADDR_W | Access byte address |
| mem_size | output | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_wdata | output | 32 | Write data, low bytes significant |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq | output | 1 | Channel interrupt |

## Verification
A register write takes effect at the clock edge that samples it, and reads are combinational, so the bench drives at the falling edge and samples one step later. The first request appears two edges after the enabling write: one edge to arm the counters, one to leave idle. Each beat then needs a read and a write acknowledge. The status and `irq` change at the edge that accepts the last write or the failing acknowledge, so the bench polls the enable bit and only then reads status. An abort is checked at the falling edge right after the write. Pause and gating are checked by counting acknowledged accesses over a quiet window, after enough cycles for one beat in flight to finish.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } eng_state_e;

    localparam logic [2:0] STS_NONE   = 3'd0;
    localparam logic [2:0] STS_DONE   = 3'd1;
    localparam logic [2:0] STS_BUSERR = 3'd2;

    // beats per burst from the 4-bit burst type code
    function automatic logic [4:0] burst_beats(input logic [3:0] code);
        case (code)
            4'hF:    burst_beats = 5'd16;
            4'hD:    burst_beats = 5'd8;
            4'hB:    burst_beats = 5'd4;
            default: burst_beats = 5'd1;
        endcase
    endfunction

    // access size code from the width field (code 3 treated as 4 bytes)
    function automatic logic [1:0] size_code(input logic [1:0] wcode);
        size_code = (wcode == 2'd3) ? 2'd2 : wcode;
    endfunction

    function automatic logic [2:0] width_bytes(input logic [1:0] wcode);
        width_bytes = 3'd1 << size_code(wcode);
    endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              done_i,
    input  logic              err_i,
    input  logic              active_i,
    input  logic [ADDR_W-1:0] sa_live_i,
    input  logic [ADDR_W-1:0] da_live_i,
    output logic              glob_en_o,
    output logic              ch_en_o,
    output logic              pause_o,
    output logic              start_o,
    output logic [3:0]        btype_o,
    output logic [CNT_W-1:0]  tcount_o,
    output logic [1:0]        wcode_o,
    output logic              fix_src_o,
    output logic              fix_dst_o,
    output logic              sa_wr_o,
    output logic              da_wr_o,
    output logic              irq_o
);

    localparam int CH_BASE = 16 * (CH_IDX + 1);
    localparam logic [REG_AW-1:0] OFF_GLOB = '0;
    localparam logic [REG_AW-1:0] OFF_CTLA = REG_AW'(CH_BASE);
    localparam logic [REG_AW-1:0] OFF_CTLB = REG_AW'(CH_BASE + 4);
    localparam logic [REG_AW-1:0] OFF_SRC  = REG_AW'(CH_BASE + 8);
    localparam logic [REG_AW-1:0] OFF_DST  = REG_AW'(CH_BASE + 12);

    typedef struct packed {
        logic             gen;
        logic             en;
        logic             pause;
        logic [4:0]       sel;
        logic [3:0]       btype;
        logic [CNT_W-1:0] tcnt;
        logic [1:0]       wcode;
        logic             fsrc;
        logic             fdst;
        logic             eie;
        logic             cie;
        logic [2:0]       sts;
        logic             start;
    } reg_state_t;

    reg_state_t q, d;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (wr_i) begin
            case (addr_i)
                OFF_GLOB: d.gen = wdata_i[31];
                OFF_CTLA: begin
                    d.en    = wdata_i[31];
                    d.pause = wdata_i[30];
                    d.sel   = wdata_i[28:24];
                    d.btype = wdata_i[23:20];
                    d.tcnt  = wdata_i[CNT_W-1:0];
                    d.start = wdata_i[31] && !q.en;
                end
                OFF_CTLB: begin
                    d.wcode = wdata_i[27:26];
                    d.fsrc  = wdata_i[25];
                    d.fdst  = wdata_i[24];
                    d.eie   = wdata_i[20];
                    d.cie   = wdata_i[19];
                    if (wdata_i[18:16] == 3'd0) begin
                        d.sts = STS_NONE;
                    end
                end
                default: ;
            endcase
        end
        if (done_i) begin
            d.en  = 1'b0;
            d.sts = STS_DONE;
        end
        if (err_i) begin
            d.en  = 1'b0;
            d.sts = STS_BUSERR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr_i)
            OFF_GLOB: rdata_o = {q.gen, 31'd0};
            OFF_CTLA: rdata_o = {q.en, q.pause, 1'b0, q.sel, q.btype, 4'd0,
                                 16'(q.tcnt)};
            OFF_CTLB: rdata_o = {4'd0, q.wcode, q.fsrc, q.fdst, 3'd0,
                                 q.eie, q.cie, q.sts, 16'd0};
            OFF_SRC:  rdata_o = 32'(sa_live_i);
            OFF_DST:  rdata_o = 32'(da_live_i);
            default:  rdata_o = 32'd0;
        endcase
    end

    assign glob_en_o = q.gen;
    assign ch_en_o   = q.en;
    assign pause_o   = q.pause;
    assign start_o   = q.start;
    assign btype_o   = q.btype;
    assign tcount_o  = q.tcnt;
    assign wcode_o   = q.wcode;
    assign fix_src_o = q.fsrc;
    assign fix_dst_o = q.fdst;
    assign sa_wr_o   = wr_i && (addr_i == OFF_SRC) && !active_i;
    assign da_wr_o   = wr_i && (addr_i == OFF_DST) && !active_i;
    assign irq_o     = ((q.sts == STS_DONE) && q.cie) ||
                       ((q.sts == STS_BUSERR) && q.eie);

    AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (!q.en && q.sts == STS_DONE)); // R6

    AST_ERR_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> (!q.en && q.sts == STS_BUSERR)); // R7

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFF_CTLB && wdata_i[18:16] == 3'd0 && !done_i && !err_i)
        |=> !irq_o); // R8

    AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFF_SRC && active_i) |-> !sa_wr_o); // R12

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_en_i,
    input  logic              ch_en_i,
    input  logic              pause_i,
    input  logic              start_i,
    input  logic [3:0]        btype_i,
    input  logic [CNT_W-1:0]  tcount_i,
    input  logic [1:0]        wcode_i,
    input  logic              fix_src_i,
    input  logic              fix_dst_i,
    input  logic              sa_wr_i,
    input  logic              da_wr_i,
    input  logic [31:0]       wdata_i,
    input  logic              mem_ack_i,
    input  logic              mem_err_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [1:0]        mem_size_o,
    output logic [31:0]       mem_wdata_o,
    output logic              done_o,
    output logic              err_o,
    output logic              active_o,
    output logic [ADDR_W-1:0] sa_o,
    output logic [ADDR_W-1:0] da_o
);

    typedef struct packed {
        eng_state_e        state;
        logic              active;
        logic [4:0]        blen;
        logic [4:0]        beat_left;
        logic [CNT_W-1:0]  burst_left;
        logic [ADDR_W-1:0] sa;
        logic [ADDR_W-1:0] da;
        logic [31:0]       data;
    } eng_t;

    eng_t q, d;
    logic [ADDR_W-1:0] step;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        err_o  = 1'b0;
        step   = ADDR_W'(width_bytes(wcode_i));
        if (sa_wr_i) d.sa = wdata_i[ADDR_W-1:0];
        if (da_wr_i) d.da = wdata_i[ADDR_W-1:0];
        if (!ch_en_i) begin
            d.state  = ST_IDLE;
            d.active = 1'b0;
        end else if (start_i) begin
            d.state      = ST_IDLE;
            d.active     = 1'b1;
            d.blen       = burst_beats(btype_i);
            d.beat_left  = burst_beats(btype_i) - 5'd1;
            d.burst_left = tcount_i;
        end else begin
            case (q.state)
                ST_IDLE: begin
                    if (q.active && glob_en_i && !pause_i) d.state = ST_RD;
                end
                ST_RD: begin
                    if (mem_ack_i) begin
                        if (mem_err_i) begin
                            err_o    = 1'b1;
                            d.active = 1'b0;
                            d.state  = ST_IDLE;
                        end else begin
                            d.data  = mem_rdata_i;
                            d.state = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (mem_ack_i) begin
                        d.state = ST_IDLE;
                        if (mem_err_i) begin
                            err_o    = 1'b1;
                            d.active = 1'b0;
                        end else begin
                            if (!fix_src_i) d.sa = q.sa + step;
                            if (!fix_dst_i) d.da = q.da + step;
                            if (q.beat_left != 5'd0) begin
                                d.beat_left = q.beat_left - 5'd1;
                            end else if (q.burst_left != '0) begin
                                d.burst_left = q.burst_left - 1'b1;
                                d.beat_left  = q.blen - 5'd1;
                            end else begin
                                done_o   = 1'b1;
                                d.active = 1'b0;
                            end
                        end
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_req_o   = ch_en_i && (q.state == ST_RD || q.state == ST_WR);
    assign mem_we_o    = (q.state == ST_WR);
    assign mem_addr_o  = (q.state == ST_WR) ? q.da : q.sa;
    assign mem_size_o  = size_code(wcode_i);
    assign mem_wdata_o = q.data;
    assign active_o    = q.active;
    assign sa_o        = q.sa;
    assign da_o        = q.da;

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RD && $past(q.state) == ST_IDLE) |-> $past(glob_en_i)); // R9

    AST_PAUSE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RD && $past(q.state) == ST_IDLE) |-> !$past(pause_i)); // R10

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en_i |=> !mem_req_o); // R11

    AST_SRC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WR && fix_src_i && q.active) |=> $stable(q.sa)); // R5

    AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WR && mem_ack_i && !mem_err_i && ch_en_i && !fix_dst_i)
        |=> (q.da == $past(q.da) + $past(step))); // R4

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |-> $past(mem_ack_i && !mem_err_i && !mem_we_o)); // R13

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic              irq
);

    logic              glob_en, ch_en, pause, start;
    logic [3:0]        btype;
    logic [CNT_W-1:0]  tcount;
    logic [1:0]        wcode;
    logic              fix_src, fix_dst, sa_wr, da_wr;
    logic              done, err, active;
    logic [ADDR_W-1:0] sa_live, da_live;

    dmac_regs #(
        .REG_AW (REG_AW),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .CH_IDX (CH_IDX)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .done_i    (done),
        .err_i     (err),
        .active_i  (active),
        .sa_live_i (sa_live),
        .da_live_i (da_live),
        .glob_en_o (glob_en),
        .ch_en_o   (ch_en),
        .pause_o   (pause),
        .start_o   (start),
        .btype_o   (btype),
        .tcount_o  (tcount),
        .wcode_o   (wcode),
        .fix_src_o (fix_src),
        .fix_dst_o (fix_dst),
        .sa_wr_o   (sa_wr),
        .da_wr_o   (da_wr),
        .irq_o     (irq)
    );

    dmac_engine #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .glob_en_i   (glob_en),
        .ch_en_i     (ch_en),
        .pause_i     (pause),
        .start_i     (start),
        .btype_i     (btype),
        .tcount_i    (tcount),
        .wcode_i     (wcode),
        .fix_src_i   (fix_src),
        .fix_dst_i   (fix_dst),
        .sa_wr_i     (sa_wr),
        .da_wr_i     (da_wr),
        .wdata_i     (reg_wdata),
        .mem_ack_i   (mem_ack),
        .mem_err_i   (mem_err),
        .mem_rdata_i (mem_rdata),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_size_o  (mem_size),
        .mem_wdata_o (mem_wdata),
        .done_o      (done),
        .err_o       (err),
        .active_o    (active),
        .sa_o        (sa_live),
        .da_o        (da_live)
    );

endmodule

// File: tb/dmac_channel_bench.sv
module dmac_channel_bench;

    localparam logic [7:0] A_GLOB = 8'h00;
    localparam logic [7:0] A_CTLA = 8'h10;
    localparam logic [7:0] A_CTLB = 8'h14;
    localparam logic [7:0] A_SRC  = 8'h18;
    localparam logic [7:0] A_DST  = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        irq;

    always #10 clk = ~clk;

    dmac_channel u_dmac_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
    } item_t;

    item_t       exp_q[$];
    logic [7:0]  mem [0:4095];
    int          checks = 0;
    int          fails = 0;
    int          wr_grants = 0;
    int          rd_grants = 0;
    logic        err_en = 1'b0;
    logic [11:0] err_addr = '0;
    logic [31:0] cur_ctla = '0;

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 7 + 53);
    endfunction

    function automatic logic [31:0] pat_word(input logic [31:0] a, input int nb);
        logic [31:0] w = '0;
        for (int k = 0; k < nb; k++) w[8*k +: 8] = pat(int'(a[11:0]) + k);
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (rst_n && mem_req) begin
            int nb;
            nb = 1 << mem_size;
            mem_ack = 1'b1;
            if (!mem_we) begin
                rd_grants++;
                mem_err = err_en && (mem_addr[11:0] == err_addr);
                mem_rdata = '0;
                for (int k = 0; k < nb; k++) mem_rdata[8*k +: 8] = mem[12'(mem_addr[11:0] + 12'(k))];
            end else begin
                wr_grants++;
                for (int k = 0; k < nb; k++) mem[12'(mem_addr[11:0] + 12'(k))] = mem_wdata[8*k +: 8];
                if (exp_q.size() == 0) begin
                    check("R3 extra beat", 32'd1, 32'd0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check("R4 address", mem_addr, e.addr);
                    check("R4 size", 32'(mem_size), 32'(e.size));
                    check("R13 data", mem_wdata, e.data);
                end
            end
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic init_mem();
        for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    endtask

    // driver: programs the channel and pushes the expected write items
    task automatic launch(input logic [31:0] sa, input logic [31:0] da, input logic [3:0] bt,
                          input logic [15:0] cnt, input logic [1:0] wc, input logic fs,
                          input logic fd, input logic eie, input logic cie, input int limit);
        int blen, nb, total;
        logic [1:0] sz;
        item_t it;
        init_mem();
        reg_write(A_SRC, sa);
        reg_write(A_DST, da);
        reg_write(A_CTLB, {4'd0, wc, fs, fd, 3'd0, eie, cie, 3'd0, 16'd0});
        blen = (bt == 4'hF) ? 16 : (bt == 4'hD) ? 8 : (bt == 4'hB) ? 4 : 1;
        sz = (wc == 2'd3) ? 2'd2 : wc;
        nb = 1 << sz;
        total = (int'(cnt) + 1) * blen;
        if (limit >= 0 && limit < total) total = limit;
        for (int i = 0; i < total; i++) begin
            it.addr = fd ? da : da + 32'(i * nb);
            it.size = sz;
            it.data = pat_word(fs ? sa : sa + 32'(i * nb), nb);
            exp_q.push_back(it);
        end
        cur_ctla = {1'b1, 1'b0, 1'b0, 5'd3, bt, 4'd0, cnt};
        reg_write(A_CTLA, cur_ctla);
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n = 0;
        do begin
            reg_read(A_CTLA, v);
            n++;
        end while (v[31] && n < 5000);
        check({req, " channel retired"}, 32'(v[31]), 32'd0);
        check({req, " all items seen"}, 32'(exp_q.size()), 32'd0);
    endtask

    task automatic read_status(output logic [2:0] s);
        logic [31:0] v;
        reg_read(A_CTLB, v);
        s = v[18:16];
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [2:0]  s;
        int g0, r0;

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(A_GLOB, v); check("R1 global", v, 32'd0);
        reg_read(A_CTLA, v); check("R1 ctla", v, 32'd0);
        reg_read(A_CTLB, v); check("R1 ctlb", v, 32'd0);
        reg_read(A_SRC, v);  check("R1 src", v, 32'd0);
        reg_read(A_DST, v);  check("R1 dst", v, 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 mem_req", 32'(mem_req), 32'd0);

        // R2 layout and readback
        reg_write(A_GLOB, 32'h8000_0000);
        reg_read(A_GLOB, v); check("R2 global enable", v, 32'h8000_0000);
        reg_write(A_SRC, 32'h0000_0123);
        reg_read(A_SRC, v); check("R2 src", v, 32'h0000_0123);
        reg_write(A_CTLB, 32'h0610_0000);
        reg_read(A_CTLB, v); check("R2 ctlb fields", v, 32'h0610_0000);

        // R3/R6: 2 bursts of 16 beats, 4-byte items, completion irq on
        launch(32'h100, 32'h800, 4'hF, 16'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, -1);
        wait_idle("R3");
        read_status(s); check("R6 status", 32'(s), 32'd1);
        check("R6 irq", 32'(irq), 32'd1);
        reg_read(A_SRC, v); check("R12 src final", v, 32'h180);
        reg_read(A_DST, v); check("R12 dst final", v, 32'h880);

        // R8: nonzero status write keeps, zero write clears
        reg_write(A_CTLB, 32'h0808_0000 | 32'h0007_0000);
        read_status(s); check("R8 status kept", 32'(s), 32'd1);
        check("R8 irq kept", 32'(irq), 32'd1);
        reg_write(A_CTLB, 32'h0808_0000);
        read_status(s); check("R8 status cleared", 32'(s), 32'd0);
        check("R8 irq cleared", 32'(irq), 32'd0);

        // R3/R4: 8 single bytes, completion irq disabled
        launch(32'h201, 32'h901, 4'hD, 16'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        wait_idle("R3");
        read_status(s); check("R6 status no-irq", 32'(s), 32'd1);
        check("R6 irq masked", 32'(irq), 32'd0);

        // R5: fixed source, halfwords, 3 bursts of 4
        launch(32'h300, 32'hA40, 4'hB, 16'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, -1);
        wait_idle("R5");
        reg_read(A_SRC, v); check("R5 src held", v, 32'h300);
        reg_read(A_DST, v); check("R4 dst advanced", v, 32'hA58);

        // R5/R3: fixed destination, other burst code -> single beats
        launch(32'h340, 32'hA00, 4'h3, 16'd4, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, -1);
        wait_idle("R3");
        reg_read(A_DST, v); check("R5 dst held", v, 32'hA00);

        // R9: master enable off holds the channel
        reg_write(A_GLOB, 32'h0);
        launch(32'h380, 32'hB00, 4'hB, 16'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, -1);
        g0 = wr_grants; r0 = rd_grants;
        repeat (30) @(posedge clk);
        check("R9 no reads", 32'(rd_grants - r0), 32'd0);
        check("R9 no writes", 32'(wr_grants - g0), 32'd0);
        reg_write(A_GLOB, 32'h8000_0000);
        wait_idle("R9");

        // R10/R12: pause mid transfer, live address, locked address
        launch(32'h400, 32'hC00, 4'hF, 16'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, -1);
        g0 = wr_grants;
        while (wr_grants - g0 < 5) @(posedge clk);
        reg_write(A_CTLA, cur_ctla | 32'h4000_0000);
        repeat (10) @(posedge clk);
        r0 = wr_grants;
        repeat (30) @(posedge clk);
        check("R10 paused", 32'(wr_grants - r0), 32'd0);
        reg_read(A_SRC, v); check("R12 live src", v, 32'h400 + 32'((wr_grants - g0) * 4));
        reg_write(A_SRC, 32'h0000_0FF0);
        reg_read(A_SRC, v); check("R12 src write ignored", v, 32'h400 + 32'((wr_grants - g0) * 4));
        reg_write(A_CTLA, cur_ctla);
        wait_idle("R10");

        // R7: error on fourth read, error irq enabled
        err_en = 1'b1; err_addr = 12'h50C;
        launch(32'h500, 32'hD00, 4'hB, 16'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3);
        wait_idle("R7");
        err_en = 1'b0;
        read_status(s); check("R7 status", 32'(s), 32'd2);
        check("R7 irq", 32'(irq), 32'd1);
        reg_read(A_DST, v); check("R7 dst stopped", v, 32'hD0C);
        reg_write(A_CTLB, 32'h0);

        // R11: abort
        launch(32'h600, 32'hE00, 4'hF, 16'd7, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, -1);
        g0 = wr_grants;
        while (wr_grants - g0 < 3) @(posedge clk);
        reg_write(A_CTLA, 32'h0);
        check("R11 req dropped", 32'(mem_req), 32'd0);
        g0 = wr_grants; r0 = rd_grants;
        repeat (30) @(posedge clk);
        check("R11 no writes", 32'(wr_grants - g0), 32'd0);
        check("R11 no reads", 32'(rd_grants - r0), 32'd0);
        read_status(s); check("R11 status untouched", 32'(s), 32'd0);
        check("R11 irq low", 32'(irq), 32'd0);
        exp_q.delete();

        summary();
        $finish;
    end

endmodule